// File: doc/BRIEF.md
# Programmable Display Clock Generator

This block produces a small set of derived pixel-style clocks from up to eight source clocks. Each generator stage picks one source, can invert that source before use, divides it by an integer between 1 and 256, and can invert the result. A bypass option routes the selected source, undivided, to the stage output. One shared control word holds a global divider enable and the gating modes for the bus-side and peripheral-side clocks. Software reaches all of this through a single-cycle memory-mapped register port that has a combinational read path.

The block runs in one system clock domain. The source clocks are slow level inputs that this clock oversamples. A stage counts rising edges of its selected source after any input inversion. It stores a new divisor or source select only at the start of an output period, so reprogramming never produces a short pulse. Bus-clock gating has three legal modes. The fourth encoding is reserved and is stored as "disabled".

Top module: `clkgen_top`

## Requirements
- R1: After synchronous reset, every register field reads zero, every `clk_out` bit is 0, and `bclk_en` and `pclk_en` are 0 while the bus is idle.
- R2: Bits [1:0] of the shared word (word index 16) set the bus-clock mode, and `bclk_en` follows it. Value 0 forces `bclk_en` low. Value 3 holds it high. Value 2 raises it only while the divider enable is set.
- R3: A write of value 1 to the bus-clock mode field is stored and read back as 0, and `bclk_en` stays low.
- R4: Bit 3 of the shared word is the peripheral-clock mode. When it is 1, `pclk_en` is always high. When it is 0, `pclk_en` is high only in cycles where `req` is high.
- R5: Bit 2 of the shared word is the global divider enable. While it is 0, every stage output holds at its output-inversion bit, and no divided or bypassed clock reaches it.
- R6: Stage n's word sits at word index 2n, and the shared word sits at index 16. Odd indices, and stage indices at or above the stage count, read zero and ignore writes. Unused bits of implemented words read zero.
- R7: A stage word holds bypass in bit 0, output inversion in bit 1, the source select in [4:2] and the divisor minus one in [12:5]. Each field reads back as written.
- R8: With divisor N (field value N-1) and N > 1, the output period is N source periods. The high phase lasts floor(N/2) source periods and the low phase lasts the rest, so even N gives 50% duty. N runs up to 256.
- R9: With divisor 1, the stage output follows the selected source level.
- R10: The source select value s in [4:2] makes `src_in[s]` the stage's source.
- R11: With bypass set, the stage output follows the selected source level whatever the divisor field holds.
- R12: Bit 4+n of the shared word inverts stage n's source before use. Bit 1 of the stage word inverts the stage output, which swaps the high and low phase lengths.
- R13: A new divisor or source select takes effect only at the next output period boundary. The period in progress completes with the old setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the sources |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 8 | Source clock levels |
| req | input | 1 | Register access strobe |
| we | input | 1 | Write when high, read when low |
| addr | input | 5 | Word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| bclk_en | output | 1 | Bus-clock gate enable |
| pclk_en | output | 1 | Peripheral-clock gate enable |
| clk_out | output | NSTAGE | Generated stage clocks |

## Verification
The divider is run with even divisors (4, and 256 at the top of the range) and with odd divisors (3 and 5). Even divisors must give equal high and low runs, and odd ones a high run one source period short, so the runs separate a correct phase split from an off-by-one counter. Each source has a distinct period, so the run length of a divided or bypassed output shows which source was actually selected. Inversion is checked by comparing phase against the live source level and by watching the odd-divisor phases swap. A divisor written in the middle of a period must leave that period's 32-cycle phases intact before the new 8-cycle phases appear, which separates deferred loading from immediate loading.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
    localparam int NUM_SRC    = 8;
    localparam int SRC_W      = $clog2(NUM_SRC);
    localparam int DIV_W      = 8;
    localparam int MAX_STAGES = 8;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 5;
    localparam int CTRL_WORD  = 16;
    localparam int STAGE_BITS = DIV_W + SRC_W + 2;

    typedef enum logic [1:0] {
        BUS_OFF  = 2'd0,
        BUS_RSVD = 2'd1,
        BUS_DYN  = 2'd2,
        BUS_ON   = 2'd3
    } bus_mode_e;

    // Field order matches the stage word layout, LSB last.
    typedef struct packed {
        logic [DIV_W-1:0] divm1;
        logic [SRC_W-1:0] src;
        logic             out_inv;
        logic             bypass;
    } stage_cfg_t;

    typedef struct packed {
        logic [MAX_STAGES-1:0] in_inv;
        logic                  periph_on;
        logic                  div_en;
        bus_mode_e             bus_mode;
    } ctrl_t;

    // The reserved encoding is stored as disabled.
    function automatic bus_mode_e legal_bus_mode(input logic [1:0] raw);
        return (raw == 2'b01) ? BUS_OFF : bus_mode_e'(raw);
    endfunction

    // Number of source edges the output stays high: floor(N/2), N = divm1 + 1.
    function automatic logic [DIV_W-1:0] high_phase(input logic [DIV_W-1:0] divm1);
        logic [DIV_W:0] n;
        n = {1'b0, divm1} + (DIV_W+1)'(1);
        return n[DIV_W:1];
    endfunction
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs import clkgen_pkg::*; #(
    parameter int NSTAGE = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output ctrl_t                   ctrl_q,
    output stage_cfg_t [NSTAGE-1:0] stage_q
);
    localparam logic [MAX_STAGES-1:0] INV_MASK = MAX_STAGES'((1 << NSTAGE) - 1);

    logic wr_ctrl;
    logic unused_hi;

    assign wr_ctrl   = req && we && (addr == ADDR_W'(CTRL_WORD));
    assign unused_hi = ^wdata[DATA_W-1:STAGE_BITS];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.bus_mode  <= legal_bus_mode(wdata[1:0]);
            ctrl_q.div_en    <= wdata[2];
            ctrl_q.periph_on <= wdata[3];
            ctrl_q.in_inv    <= wdata[4 +: MAX_STAGES] & INV_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            for (int n = 0; n < NSTAGE; n++) begin
                if (req && we && (addr == ADDR_W'(2 * n)))
                    stage_q[n] <= stage_cfg_t'(wdata[STAGE_BITS-1:0]);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_WORD))
            rdata = DATA_W'(ctrl_q);
        for (int n = 0; n < NSTAGE; n++) begin
            if (addr == ADDR_W'(2 * n))
                rdata = DATA_W'(stage_q[n]);
        end
    end
endmodule

// File: rtl/clkgen_stage.sv
module clkgen_stage import clkgen_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               en,
    input  logic               in_inv,
    input  stage_cfg_t         cfg,
    output logic               clk_out
);
    logic [SRC_W-1:0] src_act;
    logic [DIV_W-1:0] dk_act;
    logic [DIV_W-1:0] cnt;
    logic             div_q;
    logic             prev_lvl;
    logic             sel_lvl;
    logic             rise;
    logic             divided;

    assign sel_lvl = src_in[src_act] ^ in_inv;
    assign rise    = sel_lvl && !prev_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_act  <= '0;
            dk_act   <= '0;
            cnt      <= '0;
            div_q    <= 1'b0;
            prev_lvl <= 1'b0;
        end else begin
            prev_lvl <= sel_lvl;
            if (!en) begin
                // Stopped: track the config so the first edge starts a period.
                div_q   <= 1'b0;
                dk_act  <= cfg.divm1;
                src_act <= cfg.src;
                cnt     <= cfg.divm1;
            end else if (rise) begin
                if (cnt == dk_act) begin
                    // Period boundary: the only point where new settings load.
                    cnt     <= '0;
                    div_q   <= 1'b1;
                    dk_act  <= cfg.divm1;
                    src_act <= cfg.src;
                end else begin
                    cnt <= cnt + DIV_W'(1);
                    if (cnt + DIV_W'(1) == high_phase(dk_act))
                        div_q <= 1'b0;
                end
            end
        end
    end

    assign divided = (dk_act == '0) ? sel_lvl : div_q;
    assign clk_out = (en && (cfg.bypass ? sel_lvl : divided)) ^ cfg.out_inv;
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top import clkgen_pkg::*; #(
    parameter int NSTAGE = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               req,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               bclk_en,
    output logic               pclk_en,
    output logic [NSTAGE-1:0]  clk_out
);
    ctrl_t                   ctrl_q;
    stage_cfg_t [NSTAGE-1:0] stage_q;
    logic                    unused_inv;

    clkgen_regs #(.NSTAGE(NSTAGE)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .ctrl_q  (ctrl_q),
        .stage_q (stage_q)
    );

    generate
        for (genvar n = 0; n < NSTAGE; n++) begin : g_stage
            clkgen_stage u_stage (
                .clk     (clk),
                .rst     (rst),
                .src_in  (src_in),
                .en      (ctrl_q.div_en),
                .in_inv  (ctrl_q.in_inv[n]),
                .cfg     (stage_q[n]),
                .clk_out (clk_out[n])
            );
        end
    endgenerate

    assign bclk_en = (ctrl_q.bus_mode == BUS_ON) ||
                     ((ctrl_q.bus_mode == BUS_DYN) && ctrl_q.div_en);
    assign pclk_en = ctrl_q.periph_on || req;

    assign unused_inv = ^ctrl_q.in_inv;
endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk import clkgen_pkg::*; #(
    parameter int NSTAGE = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req,
    input logic                    we,
    input logic [ADDR_W-1:0]       addr,
    input logic [DATA_W-1:0]       wdata,
    input logic [DATA_W-1:0]       rdata,
    input logic                    bclk_en,
    input logic                    pclk_en,
    input logic [NSTAGE-1:0]       clk_out,
    input ctrl_t                   ctrl_q,
    input stage_cfg_t [NSTAGE-1:0] stage_q
);
    logic [NSTAGE-1:0] inv_vec;
    logic              unused_chk;

    always_comb begin
        for (int n = 0; n < NSTAGE; n++)
            inv_vec[n] = stage_q[n].out_inv;
    end
    assign unused_chk = ^{wdata, ctrl_q, stage_q};

    AST_NO_RSVD_MODE: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.bus_mode != BUS_RSVD); // R3

    AST_BUS_ON_NEXT: assert property (@(posedge clk) disable iff (rst)
        (req && we && addr == ADDR_W'(CTRL_WORD) && wdata[1:0] == 2'b11) |=> bclk_en); // R2

    AST_BUS_DYN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.bus_mode == BUS_DYN && !ctrl_q.div_en) |-> !bclk_en); // R2

    AST_PCLK_ON_ACCESS: assert property (@(posedge clk) disable iff (rst)
        req |-> pclk_en); // R4

    AST_STOPPED_OUT: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.div_en |-> (clk_out == inv_vec)); // R5

    AST_ODD_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req && !we && addr[0]) |-> (rdata == '0)); // R6

    AST_DIV_READBACK: assert property (@(posedge clk) disable iff (rst)
        (req && we && addr == '0) |=> (stage_q[0].divm1 == $past(wdata[12:5]))); // R7
endmodule

bind clkgen_top clkgen_chk #(.NSTAGE(NSTAGE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .we      (we),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .bclk_en (bclk_en),
    .pclk_en (pclk_en),
    .clk_out (clk_out),
    .ctrl_q  (ctrl_q),
    .stage_q (stage_q)
);

// File: tb/clkgen_top_test.sv
`timescale 1ns/1ps
module clkgen_top_test;
    import clkgen_pkg::*;

    localparam int NST = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        src_in = '0;
    logic              req = 1'b0;
    logic              we = 1'b0;
    logic [4:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              bclk_en;
    logic              pclk_en;
    logic [NST-1:0]    clk_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    clkgen_top #(.NSTAGE(NST)) uut (
        .clk(clk), .rst(rst), .src_in(src_in), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .bclk_en(bclk_en), .pclk_en(pclk_en), .clk_out(clk_out)
    );

    always #2.5 clk = ~clk;

    // Source k toggles every k+1 cycles: period 2(k+1) system clocks.
    int half_cnt [8];
    always @(negedge clk) begin
        for (int k = 0; k < 8; k++) begin
            if (half_cnt[k] == k) begin
                src_in[k]   <= ~src_in[k];
                half_cnt[k] <= 0;
            end else begin
                half_cnt[k] <= half_cnt[k] + 1;
            end
        end
    end

    // Run-length log of the monitored stage output.
    int   mon = 0;
    logic cur_lvl = 1'b0;
    int   cur_len = 0;
    int   nrun = 0;
    logic run_lvl [64];
    int   run_len [64];

    always @(posedge clk) begin
        if (clk_out[mon] === cur_lvl) begin
            cur_len++;
        end else begin
            if (nrun < 64) begin
                run_lvl[nrun] = cur_lvl;
                run_len[nrun] = cur_len;
                nrun++;
            end
            cur_lvl = clk_out[mon];
            cur_len = 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        req = 1'b1; we = 1'b1; addr = 5'(a); wdata = d;
        @(posedge clk); #1;
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d, output logic pc);
        req = 1'b1; we = 1'b0; addr = 5'(a);
        #1;
        d  = rdata;
        pc = pclk_en;
        @(posedge clk); #1;
        req = 1'b0;
    endtask

    function automatic logic [31:0] sw(input logic byp, input logic oinv, input int src, input int div);
        return {19'd0, 8'(div - 1), 3'(src), oinv, byp};
    endfunction

    function automatic logic [31:0] cw(input int bm, input logic en, input logic pon, input int inv);
        return {20'd0, 8'(inv), pon, en, 2'(bm)};
    endfunction

    task automatic measure(output int h, output int l);
        int guard;
        guard = 0;
        nrun = 0;
        while (nrun < 8 && guard < 6000) begin
            tick(1);
            guard++;
        end
        h = -1; l = -1;
        for (int i = 3; i < nrun - 1; i++) begin
            if (run_lvl[i] === 1'b1) begin
                h = run_len[i];
                l = run_len[i+1];
                break;
            end
        end
    endtask

    task automatic div_case(input string tag, input int word, input logic [31:0] cfg,
                            input int exp_h, input int exp_l);
        int h, l;
        wr(word, cfg);
        tick(600);
        measure(h, l);
        chk({tag, " high run"}, h, exp_h);
        chk({tag, " low run"}, l, exp_l);
    endtask

    task automatic t_reset();
        logic [31:0] d; logic pc;
        chk("R1 clk_out", clk_out, 0);
        chk("R1 bclk_en", bclk_en, 0);
        chk("R1 pclk_en idle", pclk_en, 0);
        rd(16, d, pc); chk("R1 shared word", d, 0);
        rd(0, d, pc);  chk("R1 stage0 word", d, 0);
    endtask

    task automatic t_map();
        logic [31:0] d; logic pc;
        wr(0, 32'hFFFF_FFFF);
        rd(0, d, pc); chk("R7 stage word fields", d, 32'h1FFF);
        wr(1, 32'hFFFF_FFFF);
        wr(4, 32'hFFFF_FFFF);
        rd(1, d, pc); chk("R6 odd word", d, 0);
        rd(4, d, pc); chk("R6 unimplemented stage word", d, 0);
        rd(2, d, pc); chk("R6 stage1 untouched", d, 0);
        wr(16, 32'hFFFF_FFFF);
        rd(16, d, pc); chk("R6 shared word unused bits", d, 32'h3F);
        wr(16, 0);
        wr(0, 0);
    endtask

    task automatic t_bus();
        logic [31:0] d; logic pc;
        wr(16, cw(3, 0, 0, 0)); chk("R2 mode 3", bclk_en, 1);
        wr(16, cw(2, 0, 0, 0)); chk("R2 mode 2 divider off", bclk_en, 0);
        wr(16, cw(2, 1, 0, 0)); chk("R2 mode 2 divider on", bclk_en, 1);
        wr(16, cw(0, 1, 0, 0)); chk("R2 mode 0", bclk_en, 0);
        wr(16, cw(1, 1, 0, 0));
        rd(16, d, pc); chk("R3 reserved reads 0", d[1:0], 0);
        chk("R3 reserved gate off", bclk_en, 0);
    endtask

    task automatic t_pclk();
        logic [31:0] d; logic pc;
        wr(16, cw(0, 0, 0, 0)); tick(1);
        chk("R4 dynamic idle", pclk_en, 0);
        rd(16, d, pc); chk("R4 dynamic during access", pc, 1);
        wr(16, cw(0, 0, 1, 0)); tick(1);
        chk("R4 always on idle", pclk_en, 1);
    endtask

    task automatic t_divide();
        wr(16, cw(0, 1, 0, 0));
        mon = 0;
        div_case("R8 N=4", 0, sw(0, 0, 0, 4), 4, 4);
        div_case("R8 N=3 odd", 0, sw(0, 0, 0, 3), 2, 4);
        div_case("R8 N=256 max", 0, sw(0, 0, 0, 256), 256, 256);
        div_case("R9 N=1 src0", 0, sw(0, 0, 0, 1), 1, 1);
        div_case("R9 N=1 src4", 0, sw(0, 0, 4, 1), 5, 5);
        div_case("R10 src5 N=2", 0, sw(0, 0, 5, 2), 12, 12);
        mon = 1;
        div_case("R8 stage1 N=5 src2", 2, sw(0, 0, 2, 5), 12, 18);
        mon = 0;
        div_case("R11 bypass src2", 0, sw(1, 0, 2, 4), 3, 3);
    endtask

    task automatic t_invert();
        int bad;
        wr(16, cw(0, 1, 0, 1));
        wr(0, sw(1, 0, 1, 4));
        tick(100);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            if (clk_out[0] !== ~src_in[1]) bad++;
            tick(1);
        end
        chk("R12 input inversion phase", bad, 0);
        wr(16, cw(0, 1, 0, 0));
        div_case("R12 output inversion N=3", 0, sw(0, 1, 0, 3), 4, 2);
    endtask

    task automatic t_enable();
        int ones;
        wr(0, sw(0, 0, 0, 4));
        tick(100);
        wr(16, cw(0, 0, 0, 0));
        tick(3);
        nrun = 0;
        tick(100);
        chk("R5 stopped no edges", nrun, 0);
        chk("R5 stopped level", cur_lvl, 0);
        wr(0, sw(0, 1, 0, 4));
        chk("R5 stopped at out-inv level", clk_out[0], 1);
        wr(0, sw(1, 0, 0, 1));
        ones = 0;
        for (int i = 0; i < 20; i++) begin
            if (clk_out[0] !== 1'b0) ones++;
            tick(1);
        end
        chk("R5 bypass blocked while stopped", ones, 0);
    endtask

    task automatic t_change();
        int guard;
        wr(16, cw(0, 1, 0, 0));
        wr(0, sw(0, 0, 3, 8));
        tick(600);
        guard = 0;
        while (!(cur_lvl === 1'b1 && cur_len == 1) && guard < 2000) begin
            tick(1);
            guard++;
        end
        nrun = 0;
        wr(0, sw(0, 0, 3, 2));
        guard = 0;
        while (nrun < 4 && guard < 2000) begin
            tick(1);
            guard++;
        end
        chk("R13 old high kept", run_len[0], 32);
        chk("R13 old low kept", run_len[1], 32);
        chk("R13 new high", run_len[2], 8);
        chk("R13 new low", run_len[3], 8);
    endtask

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_map();
        t_bus();
        t_pclk();
        t_divide();
        t_invert();
        t_enable();
        t_change();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule